// File: doc/BRIEF.md
# In-Order Issue Interlock Scoreboard

This block is the issue-stage control of a short in-order pipeline. Each cycle it may be offered one decoded instruction: an operation class, a destination register and up to two source registers, each with a use flag, plus a tag. Every register has a small countdown of the cycles left before its pending result is written. The block checks that countdown to decide whether the offered instruction can issue in the current cycle. When it cannot, ready drops, and the instruction and everything behind it stay where they are until the hazard clears.

On issue the block starts the destination register's countdown from the latency of the class. Loads and stores take four execute cycles and floating add and multiply take three. The result is written in the last execute cycle. The block also reports, with the issue pulse, the cycle number on which that writeback happens. A register written in a cycle can be read by an instruction issuing in that same cycle, so a dependent instruction issues in its producer's last execute cycle. The block has a free-running cycle number that is cleared by reset. A write-after-write conflict is avoided by holding any instruction whose destination still has a write outstanding.

Top module: `issue_scoreboard`

## Requirements
- R1: While reset is asserted, inReady and outIssue are low. After reset releases, every register is free, so an instruction reading any register issues in the first cycle after release, which is cycle number 0. This holds even when a write was pending before reset.
- R2: The class codes are 0 load, 1 store, 2 floating add and 3 floating multiply. Loads and stores have latency 4 and floating add and multiply have latency 3. With each issue, outWbCycle equals the cycle number of the issue cycle plus that latency.
- R3: An instruction whose used source register names the destination of a producer that issued in cycle t with latency L does not issue before cycle t+L. If nothing else blocks it, it issues in cycle t+L. This applies to either source operand.
- R4: An instruction with a used destination that names the destination of a producer issued in cycle t with latency L does not issue before cycle t+L+1. If nothing else blocks it, it issues in cycle t+L+1.
- R5: Issue is in order. While the offered instruction is blocked, inReady is low and no issue pulse appears. The held instruction issues in the first cycle its hazards allow, and tags leave in the order they were offered.
- R6: Register fields whose use flag is low are ignored. A store never reserves its destination field, so a following instruction that reads that register issues in the next cycle.
- R7: outIssue is high exactly in the cycles where inValid and inReady are both high, and outTag then equals inTag.
- R8: The program of two loads, a float add, a store, two loads, a float multiply and a store is offered back to back. Its issue cycles span 18 cycles from the first to the last, counted inclusively. The reordered version of four loads, the add, the multiply and then the two stores spans 11 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An instruction is offered at issue |
| inReady | output | 1 | The offered instruction may issue this cycle |
| inClass | input | 2 | Operation class: 0 load, 1 store, 2 float add, 3 float multiply |
| inUseDst | input | 1 | The destination field is used |
| inDst | input | REG_W | Destination register index |
| inUseA | input | 1 | Source A is used |
| inSrcA | input | REG_W | Source A register index |
| inUseB | input | 1 | Source B is used |
| inSrcB | input | REG_W | Source B register index |
| inTag | input | TAG_W | Instruction tag |
| outIssue | output | 1 | Issue pulse |
| outTag | output | TAG_W | Tag of the issuing instruction |
| outWbCycle | output | CYC_W | Cycle number on which the issued result is written |

## Verification
The issue decision and the writeback cycle are combinational in the cycle the instruction is offered. The bench therefore samples outIssue, outTag and outWbCycle at the falling edge of that same cycle, and compares the result with a cycle number it counts itself. The hazard cases are measured as the distance between the producer's issue cycle and the consumer's issue cycle. That distance must be the latency L for a read-after-write, L+1 for a write-after-write, and 1 when no hazard exists. It is swept over all four classes and both source operands. The distance is exact, not just a lower bound. Every falling edge on which a held instruction does not issue also checks that inReady is low.

// File: rtl/isb_pkg.sv
package isb_pkg;

  localparam int LAT_W = 4;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FADD  = 2'd2,
    OP_FMUL  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic             issue;
    logic             reserve;
    logic [LAT_W-1:0] lat;
  } isbStrobe_t;

endpackage

// File: rtl/isb_ctrl.sv
module isb_ctrl
  import isb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int LAT_MEM  = 4,
  parameter int LAT_FP   = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [1:0]          inClass,
  input  logic                inUseDst,
  input  logic [REG_W-1:0]    inDst,
  input  logic                inUseA,
  input  logic [REG_W-1:0]    inSrcA,
  input  logic                inUseB,
  input  logic [REG_W-1:0]    inSrcB,
  input  logic [NUM_REGS-1:0] srcBusy,
  input  logic [NUM_REGS-1:0] dstPend,
  output logic                inReady,
  output isbStrobe_t          strobe
);

  opClass_e opClass;
  logic     writesDst;
  logic     hazA;
  logic     hazB;
  logic     hazD;
  logic     stall;

  always_comb begin
    opClass   = opClass_e'(inClass);
    writesDst = inUseDst && (opClass != OP_STORE);
    hazA      = inUseA && srcBusy[inSrcA];
    hazB      = inUseB && srcBusy[inSrcB];
    hazD      = writesDst && dstPend[inDst];
    stall     = hazA || hazB || hazD;
    inReady   = rst_n && !stall;

    strobe.issue   = inValid && inReady;
    strobe.reserve = strobe.issue && writesDst;
    if (opClass == OP_LOAD || opClass == OP_STORE)
      strobe.lat = LAT_W'(LAT_MEM);
    else
      strobe.lat = LAT_W'(LAT_FP);
  end

endmodule

// File: rtl/isb_datapath.sv
module isb_datapath
  import isb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int CYC_W    = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  isbStrobe_t          strobe,
  input  logic [REG_W-1:0]    inDst,
  input  logic [TAG_W-1:0]    inTag,
  output logic [NUM_REGS-1:0] srcBusy,
  output logic [NUM_REGS-1:0] dstPend,
  output logic                outIssue,
  output logic [TAG_W-1:0]    outTag,
  output logic [CYC_W-1:0]    outWbCycle
);

  logic [CYC_W-1:0] cycleCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cycleCnt <= '0;
    else        cycleCnt <= cycleCnt + 1'b1;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [LAT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        remain <= '0;
      else if (strobe.reserve && inDst == REG_W'(r))
        remain <= strobe.lat;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end

    // readable once the count reaches its final (write) cycle
    assign srcBusy[r] = remain > LAT_W'(1);
    assign dstPend[r] = remain != '0;
  end

  assign outIssue   = strobe.issue;
  assign outTag     = inTag;
  assign outWbCycle = cycleCnt + CYC_W'(strobe.lat);

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import isb_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 4,
  parameter int CYC_W    = 16,
  parameter int LAT_MEM  = 4,
  parameter int LAT_FP   = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inClass,
  input  logic             inUseDst,
  input  logic [REG_W-1:0] inDst,
  input  logic             inUseA,
  input  logic [REG_W-1:0] inSrcA,
  input  logic             inUseB,
  input  logic [REG_W-1:0] inSrcB,
  input  logic [TAG_W-1:0] inTag,
  output logic             outIssue,
  output logic [TAG_W-1:0] outTag,
  output logic [CYC_W-1:0] outWbCycle
);

  isbStrobe_t          strobe;
  logic [NUM_REGS-1:0] srcBusy;
  logic [NUM_REGS-1:0] dstPend;

  isb_ctrl #(
    .NUM_REGS(NUM_REGS), .LAT_MEM(LAT_MEM), .LAT_FP(LAT_FP)
  ) u_ctrl (
    .rst_n(rst_n), .inValid(inValid), .inClass(inClass),
    .inUseDst(inUseDst), .inDst(inDst),
    .inUseA(inUseA), .inSrcA(inSrcA),
    .inUseB(inUseB), .inSrcB(inSrcB),
    .srcBusy(srcBusy), .dstPend(dstPend),
    .inReady(inReady), .strobe(strobe)
  );

  isb_datapath #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .CYC_W(CYC_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inDst(inDst), .inTag(inTag),
    .srcBusy(srcBusy), .dstPend(dstPend),
    .outIssue(outIssue), .outTag(outTag), .outWbCycle(outWbCycle)
  );

endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
  parameter int REG_W   = 3,
  parameter int TAG_W   = 4,
  parameter int CYC_W   = 16,
  parameter int LAT_MEM = 4,
  parameter int LAT_FP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic [1:0]       inClass,
  input logic             inUseDst,
  input logic [REG_W-1:0] inDst,
  input logic             inUseA,
  input logic [REG_W-1:0] inSrcA,
  input logic             inUseB,
  input logic [REG_W-1:0] inSrcB,
  input logic [TAG_W-1:0] inTag,
  input logic             outIssue,
  input logic [TAG_W-1:0] outTag,
  input logic [CYC_W-1:0] outWbCycle
);

  logic [CYC_W-1:0] chkCyc;
  logic [CYC_W-1:0] expLat;
  logic             prodWrites;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chkCyc <= '0;
    else        chkCyc <= chkCyc + 1'b1;
  end

  assign expLat     = (inClass < 2'd2) ? CYC_W'(LAT_MEM) : CYC_W'(LAT_FP);
  assign prodWrites = outIssue && inUseDst && (inClass != 2'd1);

  // R2
  wb_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outIssue |-> outWbCycle == chkCyc + expLat);

  // R3
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prodWrites |=> !(outIssue && ((inUseA && inSrcA == $past(inDst)) ||
                                  (inUseB && inSrcB == $past(inDst)))));

  // R4
  waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prodWrites |=> !(outIssue && inUseDst && inClass != 2'd1 &&
                     inDst == $past(inDst)));

  // R5
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inReady) |-> !outIssue);

  // R7
  issue_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outIssue |-> (inValid && inReady && outTag == inTag));

endmodule

bind issue_scoreboard isb_checker #(
  .REG_W(REG_W), .TAG_W(TAG_W), .CYC_W(CYC_W),
  .LAT_MEM(LAT_MEM), .LAT_FP(LAT_FP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .inClass(inClass), .inUseDst(inUseDst), .inDst(inDst),
  .inUseA(inUseA), .inSrcA(inSrcA), .inUseB(inUseB), .inSrcB(inSrcB),
  .inTag(inTag), .outIssue(outIssue), .outTag(outTag),
  .outWbCycle(outWbCycle)
);

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;

  localparam int REG_W = 3;
  localparam int TAG_W = 4;
  localparam int CYC_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [1:0]       inClass = '0;
  logic             inUseDst = 1'b0;
  logic [REG_W-1:0] inDst = '0;
  logic             inUseA = 1'b0;
  logic [REG_W-1:0] inSrcA = '0;
  logic             inUseB = 1'b0;
  logic [REG_W-1:0] inSrcB = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic             outIssue;
  logic [TAG_W-1:0] outTag;
  logic [CYC_W-1:0] outWbCycle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastIssue = 0;
  bit done = 1'b0;

  issue_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inClass(inClass), .inUseDst(inUseDst), .inDst(inDst),
    .inUseA(inUseA), .inSrcA(inSrcA), .inUseB(inUseB), .inSrcB(inSrcB),
    .inTag(inTag), .outIssue(outIssue), .outTag(outTag),
    .outWbCycle(outWbCycle)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int latOf(input int c);
    return (c < 2) ? 4 : 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    chk(inReady == 1'b0 && outIssue == 1'b0, "R1 reset quiet", int'(inReady), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  // offers one instruction (called just after a rising edge); returns its issue cycle
  task automatic offer(input int c, input bit ud, input int d, input bit ua, input int a,
                       input bit ub, input int b, input int tag, output int when);
    int waits = 0;
    inValid = 1'b1; inClass = 2'(c); inUseDst = ud; inDst = REG_W'(d);
    inUseA = ua; inSrcA = REG_W'(a); inUseB = ub; inSrcB = REG_W'(b);
    inTag = TAG_W'(tag);
    forever begin
      @(negedge clk);
      if (outIssue) break;
      chk(inReady == 1'b0, "R5 ready low while held", int'(inReady), 0);
      waits++;
      if (waits > 50) begin
        chk(1'b0, "R5 held instruction never issued", waits, 0);
        break;
      end
    end
    when = cyc;
    lastIssue = cyc;
    chk(int'(outTag) == tag, "R7 tag", int'(outTag), tag);
    chk(int'(outWbCycle) == cyc + latOf(c), "R2 writeback cycle",
        int'(outWbCycle), cyc + latOf(c));
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t0, t1, first;
    // reset state
    @(negedge clk);
    chk(inReady == 1'b0 && outIssue == 1'b0, "R1 in reset", int'(inReady), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R3 read-after-write sweep, both source operands
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        doReset();
        offer(p, 1, 1, 0, 0, 0, 0, 1, t0);
        offer(2, 1, 5, s == 0, 1, s == 1, 1, 2, t1);
        chk(t1 - t0 == ((p == 1) ? 1 : latOf(p)),
            (p == 1) ? "R6 store reserves nothing" : "R3 raw distance",
            t1 - t0, (p == 1) ? 1 : latOf(p));
      end
    end

    // R4 write-after-write sweep
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q += 2) begin
        doReset();
        offer(p, 1, 2, 0, 0, 0, 0, 3, t0);
        offer(q, 1, 2, 0, 0, 0, 0, 4, t1);
        chk(t1 - t0 == ((p == 1) ? 1 : latOf(p) + 1),
            (p == 1) ? "R6 store dst free" : "R4 waw distance",
            t1 - t0, (p == 1) ? 1 : latOf(p) + 1);
      end
    end

    // R6 unused operand fields ignored
    doReset();
    offer(3, 1, 3, 0, 0, 0, 0, 5, t0);
    offer(2, 0, 3, 0, 3, 0, 3, 6, t1);
    chk(t1 - t0 == 1, "R6 unused fields", t1 - t0, 1);

    // R1 reset clears a pending write
    doReset();
    offer(0, 1, 4, 0, 0, 0, 0, 7, t0);
    rst_n = 1'b0;
    inValid = 1'b1; inClass = 2'd2; inUseDst = 1'b1; inDst = 3'd6;
    inUseA = 1'b1; inSrcA = 3'd4; inUseB = 1'b0; inTag = 4'd8;
    @(negedge clk);
    chk(inReady == 1'b0 && outIssue == 1'b0, "R1 held dropped in reset", int'(outIssue), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    offer(2, 1, 6, 1, 4, 0, 0, 8, t1);
    chk(t1 == 0, "R1 free after reset", t1, 0);

    // R8 original program: ld r1, ld r2, fadd r3=r1+r2, st r3, ld r4, ld r5, fmul r6, st r6
    doReset();
    offer(0, 1, 1, 0, 0, 0, 0, 0, first);
    offer(0, 1, 2, 0, 0, 0, 0, 1, t1);
    offer(2, 1, 3, 1, 1, 1, 2, 2, t1);
    chk(t1 - first == 5, "R3 add waits for second load", t1 - first, 5);
    offer(1, 0, 0, 0, 0, 1, 3, 3, t1);
    chk(t1 - first == 8, "R3 store waits for add", t1 - first, 8);
    offer(0, 1, 4, 0, 0, 0, 0, 4, t1);
    offer(0, 1, 5, 0, 0, 0, 0, 5, t1);
    offer(3, 1, 6, 1, 4, 1, 5, 6, t1);
    offer(1, 0, 0, 0, 0, 1, 6, 7, t1);
    chk(t1 - first + 1 == 18, "R8 original span", t1 - first + 1, 18);

    // R8 reordered program
    doReset();
    offer(0, 1, 1, 0, 0, 0, 0, 8, first);
    offer(0, 1, 2, 0, 0, 0, 0, 9, t1);
    offer(0, 1, 4, 0, 0, 0, 0, 10, t1);
    offer(0, 1, 5, 0, 0, 0, 0, 11, t1);
    offer(2, 1, 3, 1, 1, 1, 2, 12, t1);
    offer(3, 1, 6, 1, 4, 1, 5, 13, t1);
    offer(1, 0, 0, 0, 0, 1, 3, 14, t1);
    offer(1, 0, 0, 0, 0, 1, 6, 15, t1);
    chk(t1 - first + 1 == 11, "R8 reordered span", t1 - first + 1, 11);

    // R7 no issue when nothing offered
    @(negedge clk);
    chk(outIssue == 1'b0, "R7 idle no issue", int'(outIssue), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule